// File: doc/BRIEF.md
# Sectored Decoded-Instruction Cache

This block holds instructions that have already been decoded, so that a single-issue, in-order pipeline can skip both the instruction fetch and the decode step when a lookup hits. A lookup presents a fetch address. One cycle later the block returns a hit flag and the narrow decoded word held for that address. The decoder writes into the cache through a fill port that carries the fetch address, the decoded word and a flag. The flag says whether the decoded form fits the reduced slot width. Only instructions marked this way are stored.

The storage is sectored and direct-mapped. Each sector has one tag, and that tag covers several neighbouring lines of instructions, which keeps tag storage small. Each instruction slot has its own valid bit, so a slot can be filled on its own without fetching the rest of its line. With the default parameters there are 8 sectors, each of 4 lines of 4 instructions, and each slot is 32 bits wide, for 512 bytes of decoded storage. A flush input invalidates the whole cache in one cycle.

Top module: `dec_sector_cache`

## Requirements
- R1: After reset `hit` is low and every slot is invalid, so any lookup misses.
- R2: A lookup with `lookupEn` high hits when the addressed sector's tag matches and the addressed slot is valid. `hit` and `hitWord` (the stored word) appear on the clock edge that follows the one at which the address is sampled.
- R3: A cacheable fill validates only its own slot. Other slots under the same tag stay invalid until they are filled.
- R4: A fill with `fillCacheable` low has no effect. It stores no word, changes no tag and clears no valid bit.
- R5: A cacheable fill whose tag differs from the sector's tag replaces that tag. It clears every other slot valid bit in the sector and validates only the written slot.
- R6: Address fields are as follows: bits [1:0] are ignored, bits [5:2] select the slot within the sector, bits [8:6] select the sector and bits [31:9] form the tag. Sectors are independent of each other.
- R7: `flush` invalidates every slot in one cycle, and a fill in the same cycle is dropped.
- R8: A fill and a lookup to the same slot in the same cycle return the contents from before the fill. The new word is visible from the next lookup.
- R9: `hit` is low in the cycle after a clock edge at which `lookupEn` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupEn | input | 1 | Lookup request |
| lookupAddr | input | 32 | Fetch address to look up |
| hit | output | 1 | Registered hit flag |
| hitWord | output | 32 | Registered decoded word |
| fillEn | input | 1 | Fill request from the decoder |
| fillAddr | input | 32 | Fetch address of the filled instruction |
| fillCacheable | input | 1 | Decoded form fits a slot |
| fillWord | input | 32 | Decoded word to store |
| flush | input | 1 | Invalidate the whole cache |

## Verification
The bench builds the block with its default parameters: 8 sectors of 16 slots and 32-bit slots. Because of this, the tag begins at address bit 9, and the bench can reach sector aliasing, tag replacement and per-slot validity with hand-picked addresses. Slots are aligned, so the partial-sector cases can be reached directly. Replacing a tag while other slots still hold data, a fill and a lookup colliding in the same cycle, and a flush colliding with a fill are the orderings that matter here.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef struct packed {
    logic flushAll;
    logic fillWrite;
    logic fillReplace;
  } dscStrobe_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fillEn,
  input  logic       fillCacheable,
  input  logic       flush,
  input  logic       fillTagHit,
  output dscStrobe_t strb
);
  always_comb begin
    strb.flushAll    = flush;
    strb.fillWrite   = fillEn && fillCacheable && !flush;
    strb.fillReplace = strb.fillWrite && !fillTagHit;
  end

  // R4: a fill that does not fit a slot never writes
  assert_uncacheable_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fillEn && !fillCacheable) |-> !strb.fillWrite);
  // R7: flush takes precedence over a fill
  assert_flush_beats_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!strb.fillWrite && !strb.fillReplace));
endmodule

// File: rtl/dsc_data.sv
module dsc_data
  import dsc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SECTORS = 8,
  parameter int SLOTS   = 16,
  parameter int SLOT_W  = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dscStrobe_t        strb,
  input  logic              lookupEn,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [SLOT_W-1:0] fillWord,
  output logic              fillTagHit,
  output logic              hitQ,
  output logic [SLOT_W-1:0] wordQ
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int SLOT_IW = $clog2(SLOTS);
  localparam int OFF_LO = 2;
  localparam int TAG_LO = OFF_LO + SLOT_IW + SEC_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  logic [TAG_W-1:0]  tagMem   [SECTORS];
  logic [SLOTS-1:0]  validMem [SECTORS];
  logic [SLOT_W-1:0] dataMem  [SECTORS*SLOTS];
  logic [SECTORS-1:0] secAny;

  logic [SLOT_IW-1:0] lkSlot, flSlot;
  logic [SEC_W-1:0]   lkSec,  flSec;
  logic [TAG_W-1:0]   lkTag,  flTag;
  logic               unusedOk;

  assign lkSlot = lookupAddr[OFF_LO +: SLOT_IW];
  assign lkSec  = lookupAddr[OFF_LO+SLOT_IW +: SEC_W];
  assign lkTag  = lookupAddr[ADDR_W-1:TAG_LO];
  assign flSlot = fillAddr[OFF_LO +: SLOT_IW];
  assign flSec  = fillAddr[OFF_LO+SLOT_IW +: SEC_W];
  assign flTag  = fillAddr[ADDR_W-1:TAG_LO];
  assign unusedOk = ^{lookupAddr[OFF_LO-1:0], fillAddr[OFF_LO-1:0]};

  assign fillTagHit = (tagMem[flSec] == flTag);

  for (genvar s = 0; s < SECTORS; s++) begin : gSector
    always_ff @(posedge clk) begin
      if (!rst_n || strb.flushAll) begin
        tagMem[s]   <= '0;
        validMem[s] <= '0;
      end else if (strb.fillWrite && flSec == SEC_W'(s)) begin
        if (strb.fillReplace) begin
          tagMem[s]   <= flTag;
          validMem[s] <= SLOTS'(1) << flSlot;
        end else begin
          validMem[s][flSlot] <= 1'b1;
        end
      end
    end
    assign secAny[s] = |validMem[s];

    // R5: a tag replacement leaves exactly the written slot valid
    assert_replace_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.fillReplace && flSec == SEC_W'(s)) |=> ($countones(validMem[s]) == 1));
    // R3: a cacheable fill validates its slot
    assert_fill_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.fillWrite && flSec == SEC_W'(s)) |=> validMem[s][$past(flSlot)]);
  end

  always_ff @(posedge clk) begin
    if (strb.fillWrite) dataMem[{flSec, flSlot}] <= fillWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitQ  <= 1'b0;
      wordQ <= '0;
    end else begin
      hitQ  <= lookupEn && (tagMem[lkSec] == lkTag) && validMem[lkSec][lkSlot];
      wordQ <= dataMem[{lkSec, lkSlot}];
    end
  end

  // R7: after a flush nothing is valid
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flushAll |=> (secAny == '0));
  // R9: no request, no hit
  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupEn |=> !hitQ);
endmodule

// File: rtl/dec_sector_cache.sv
module dec_sector_cache
  import dsc_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int SECTORS          = 8,
  parameter int LINES_PER_SECTOR = 4,
  parameter int INSTR_PER_LINE   = 4,
  parameter int SLOT_W           = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupEn,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [SLOT_W-1:0] hitWord,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              fillCacheable,
  input  logic [SLOT_W-1:0] fillWord,
  input  logic              flush
);
  localparam int SLOTS = LINES_PER_SECTOR * INSTR_PER_LINE;

  dscStrobe_t strb;
  logic       fillTagHit;

  dsc_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .fillEn(fillEn), .fillCacheable(fillCacheable),
    .flush(flush), .fillTagHit(fillTagHit), .strb(strb)
  );

  dsc_data #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .lookupEn(lookupEn),
    .lookupAddr(lookupAddr), .fillAddr(fillAddr), .fillWord(fillWord),
    .fillTagHit(fillTagHit), .hitQ(hit), .wordQ(hitWord)
  );
endmodule

// File: tb/tb_dec_sector_cache.sv
module tb_dec_sector_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupEn = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        hit;
  logic [31:0] hitWord;
  logic        fillEn = 1'b0;
  logic [31:0] fillAddr = '0;
  logic        fillCacheable = 1'b0;
  logic [31:0] fillWord = '0;
  logic        flush = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dec_sector_cache dut (
    .clk(clk), .rst_n(rst_n), .lookupEn(lookupEn), .lookupAddr(lookupAddr),
    .hit(hit), .hitWord(hitWord), .fillEn(fillEn), .fillAddr(fillAddr),
    .fillCacheable(fillCacheable), .fillWord(fillWord), .flush(flush)
  );

  function automatic logic [31:0] mkAddr(input int tag, input int sec, input int slot);
    return {23'(tag), 3'(sec), 4'(slot), 2'b00};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [31:0] a, input logic [31:0] w, input logic c);
    @(negedge clk);
    fillEn = 1'b1; fillAddr = a; fillWord = w; fillCacheable = c;
    @(negedge clk);
    fillEn = 1'b0; fillCacheable = 1'b0;
  endtask

  task automatic doLookup(input logic [31:0] a, output logic h, output logic [31:0] w);
    @(negedge clk);
    lookupEn = 1'b1; lookupAddr = a;
    @(posedge clk); #1;
    lookupEn = 1'b0;
    h = hit; w = hitWord;
  endtask

  task automatic expectHit(input logic [31:0] a, input logic [31:0] w, input string req);
    logic h; logic [31:0] d;
    doLookup(a, h, d);
    check(h === 1'b1, {req, " hit"}, 32'(h), 32'd1);
    check(d === w, {req, " word"}, d, w);
  endtask

  task automatic expectMiss(input logic [31:0] a, input string req);
    logic h; logic [31:0] d;
    doLookup(a, h, d);
    check(h === 1'b0, {req, " miss"}, 32'(h), 32'd0);
  endtask

  task automatic testReset;
    check(hit === 1'b0, "R1 hit after reset", 32'(hit), 32'd0);
    expectMiss(mkAddr(0, 0, 0), "R1 tag zero");
    expectMiss(mkAddr(0, 7, 15), "R1 last slot");
  endtask

  task automatic testBasic;
    doFill(mkAddr(5, 1, 3), 32'hA000_0013, 1'b1);
    expectHit(mkAddr(5, 1, 3), 32'hA000_0013, "R2 basic");
  endtask

  task automatic testSlotIndep;
    expectMiss(mkAddr(5, 1, 4), "R3 neighbour slot");
    doFill(mkAddr(5, 1, 4), 32'hA000_0014, 1'b1);
    expectHit(mkAddr(5, 1, 4), 32'hA000_0014, "R3 second slot");
    expectHit(mkAddr(5, 1, 3), 32'hA000_0013, "R3 first slot kept");
  endtask

  task automatic testUncacheable;
    doFill(mkAddr(5, 1, 5), 32'hBAD0_0015, 1'b0);
    expectMiss(mkAddr(5, 1, 5), "R4 not stored");
    doFill(mkAddr(6, 1, 3), 32'hBAD0_0063, 1'b0);
    expectHit(mkAddr(5, 1, 3), 32'hA000_0013, "R4 tag unchanged");
    expectMiss(mkAddr(6, 1, 3), "R4 other tag");
  endtask

  task automatic testReplace;
    doFill(mkAddr(9, 1, 0), 32'hC000_0910, 1'b1);
    expectHit(mkAddr(9, 1, 0), 32'hC000_0910, "R5 new tag");
    expectMiss(mkAddr(9, 1, 3), "R5 old slot cleared under new tag");
    expectMiss(mkAddr(5, 1, 3), "R5 old tag gone");
  endtask

  task automatic testDirectMap;
    doFill(mkAddr(3, 2, 0), 32'hD000_0320, 1'b1);
    expectHit(mkAddr(9, 1, 0), 32'hC000_0910, "R6 sector 1 intact");
    expectHit(mkAddr(3, 2, 0), 32'hD000_0320, "R6 sector 2");
    expectHit(mkAddr(3, 2, 0) | 32'h3, 32'hD000_0320, "R6 low bits ignored");
    expectMiss(mkAddr(3, 3, 0), "R6 sector field");
  endtask

  task automatic testSameCycle;
    logic h; logic [31:0] d;
    doFill(mkAddr(4, 3, 7), 32'hE000_0001, 1'b1);
    @(negedge clk);
    fillEn = 1'b1; fillAddr = mkAddr(4, 3, 7); fillWord = 32'hE000_0002; fillCacheable = 1'b1;
    lookupEn = 1'b1; lookupAddr = mkAddr(4, 3, 7);
    @(posedge clk); #1;
    fillEn = 1'b0; fillCacheable = 1'b0; lookupEn = 1'b0;
    check(hit === 1'b1 && hitWord === 32'hE000_0001, "R8 old word", hitWord, 32'hE000_0001);
    expectHit(mkAddr(4, 3, 7), 32'hE000_0002, "R8 new word");
    @(negedge clk);
    fillEn = 1'b1; fillAddr = mkAddr(4, 3, 8); fillWord = 32'hE000_0008; fillCacheable = 1'b1;
    lookupEn = 1'b1; lookupAddr = mkAddr(4, 3, 8);
    @(posedge clk); #1;
    fillEn = 1'b0; fillCacheable = 1'b0; lookupEn = 1'b0;
    h = hit; d = hitWord;
    check(h === 1'b0, "R8 empty slot misses", 32'(h), 32'd0);
    expectHit(mkAddr(4, 3, 8), 32'hE000_0008, "R8 later hit");
  endtask

  task automatic testIdle;
    @(negedge clk);
    lookupEn = 1'b0; lookupAddr = mkAddr(4, 3, 8);
    @(posedge clk); #1;
    check(hit === 1'b0, "R9 no request", 32'(hit), 32'd0);
  endtask

  task automatic testFlush;
    @(negedge clk);
    flush = 1'b1;
    fillEn = 1'b1; fillAddr = mkAddr(2, 4, 1); fillWord = 32'hF000_0041; fillCacheable = 1'b1;
    @(negedge clk);
    flush = 1'b0; fillEn = 1'b0; fillCacheable = 1'b0;
    expectMiss(mkAddr(9, 1, 0), "R7 flushed sector 1");
    expectMiss(mkAddr(3, 2, 0), "R7 flushed sector 2");
    expectMiss(mkAddr(4, 3, 7), "R7 flushed sector 3");
    expectMiss(mkAddr(2, 4, 1), "R7 fill dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    testReset();
    testBasic();
    testSlotIndep();
    testUncacheable();
    testReplace();
    testDirectMap();
    testSameCycle();
    testIdle();
    testFlush();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule